// File: doc/BRIEF.md
# Shared-Timer Debounce Filter

This block cleans up a bank of 32 slow input pins, such as buttons, jumpers and presence detects, before the rest of the chip uses them. It does not give each pin its own period register. Instead it keeps three debounce periods, counted in clock cycles, that all pins share. Each pin picks one of the three, or picks none and bypasses the filter. The choice is a two-bit timer index. The index is split across two 32-bit select registers, with one bit per pin in each.

Every pin first passes through a synchroniser. The pin's filtered output then flips only once the synchronised level has disagreed with it, without a break, for the number of cycles set by the selected timer. Software configures the block through a simple word-wide register port. To change one pin's index, software reads a select register, changes that pin's bit and writes the word back. Because the periods are shared, rewriting one period retunes every pin that uses that timer at once.

Top module: `shared_debounce_filter`

## Requirements
- R1: A write with `wr_en` high stores the whole `wdata` word at the clock edge. The high-index-bit select register is at 0x40 and the low-index-bit select register is at 0x44. The periods of timers 1, 2 and 3 are at 0x50, 0x54 and 0x58. `rdata` returns the addressed register combinationally.
- R2: Writes to any other address change no register and no output, and reads of such addresses return 0.
- R3: Pin p uses timer index {sel_hi[p], sel_lo[p]}. Index 0 bypasses the filter. After an input change, `pins_out[p]` takes the new value on the 3rd rising edge: two synchroniser stages plus the output register.
- R4: For a selected period P ≥ 1, the output takes a new input level on the (2+P)-th edge after the change. It keeps the old level on the edge before that.
- R5: If the synchronised input returns to the output level before the count completes, that pin's count restarts from zero.
- R6: A selected timer whose period is 0 behaves exactly like index 0.
- R7: Rewriting a period applies, from the next cycle, to every pin that selects that timer.
- R8: When a pin's timer index changes, its count restarts and its output holds. The output then flips P+1 edges after the edge that stored the new index, where P is the new period.
- R9: During reset, all registers read 0 and `pins_out` is 0. After reset is released, each output loads the synchronised input level within three edges.
- R10: An output bit changes only to its own pin's synchronised level, and only on bypass, during warm-up, or when its count completes. Activity on one pin never moves another pin's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| pins_in | input | 32 | Raw asynchronous pin levels |
| pins_out | output | 32 | Debounced pin levels |

## Verification
A wrong count or a stale timer index shows up at the ports as an output edge that arrives too early or too late. The bench therefore checks each flip on the exact edge it is due and on the edge before it. A count that fails to clear after a bounce, or after an index change, lets the output flip several cycles early, well inside one period. A select or period bit that is stored wrongly shows up on the very next read, and it also shows up as a bypass pin that is suddenly delayed, or the reverse. A fault that leaks between lanes moves a pin that saw no stimulus, which the full-vector comparisons catch after each step.

// File: rtl/dbnc_pkg.sv
`timescale 1ns/1ps
package dbnc_pkg;
  localparam int DBN_IDX_W  = 2;
  localparam int DBN_TIMERS = (1 << DBN_IDX_W) - 1;
  localparam int DBN_CNT_W  = 32;

  typedef logic [DBN_IDX_W-1:0]        tidx_t;
  typedef logic [DBN_CNT_W-1:0]        period_t;
  typedef period_t [DBN_TIMERS-1:0]    period_bank_t;

  // Pin timer index: high bit from the first select word, low from the second.
  function automatic tidx_t timer_index(input logic hi, input logic lo);
    return {hi, lo};
  endfunction

  // Index 0 carries an implicit period of zero (no filtering).
  function automatic period_t period_for(input tidx_t idx, input period_bank_t bank);
    if (idx == '0) return '0;
    return bank[idx - tidx_t'(1)];
  endfunction

  function automatic logic is_bypass(input period_t p);
    return (p == '0);
  endfunction

  // True when the current disagreeing cycle is the P-th one in a row.
  function automatic logic count_done(input period_t cnt, input period_t p);
    logic [DBN_CNT_W:0] nxt;
    nxt = {1'b0, cnt} + 1'b1;
    return nxt >= {1'b0, p};
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
`timescale 1ns/1ps
module dbnc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[k] <= '0;
      else        stage[k] <= stage[k-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dbnc_regs.sv
`timescale 1ns/1ps
module dbnc_regs
  import dbnc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SEL_HI_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] SEL_LO_ADDR = 'h44,
  parameter int                PER_BASE    = 'h50,
  parameter int                PER_STRIDE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  period_t           wdata,
  output period_t           rdata,
  output period_t           sel_hi,
  output period_t           sel_lo,
  output period_bank_t      periods,
  output logic              addr_hit
);
  logic                  hit_hi, hit_lo;
  logic [DBN_TIMERS-1:0] hit_per;

  assign hit_hi = (addr == SEL_HI_ADDR);
  assign hit_lo = (addr == SEL_LO_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi <= '0;
      sel_lo <= '0;
    end else if (wr_en) begin
      if (hit_hi) sel_hi <= wdata;
      if (hit_lo) sel_lo <= wdata;
    end
  end

  for (genvar t = 0; t < DBN_TIMERS; t++) begin : g_timer
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PER_BASE + t * PER_STRIDE);
    assign hit_per[t] = (addr == MY_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   periods[t] <= '0;
      else if (wr_en && hit_per[t]) periods[t] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_hi) rdata = sel_hi;
    if (hit_lo) rdata = sel_lo;
    for (int t = 0; t < DBN_TIMERS; t++) begin
      if (hit_per[t]) rdata = periods[t];
    end
  end

  assign addr_hit = hit_hi | hit_lo | (|hit_per);
endmodule

// File: rtl/dbnc_lane.sv
`timescale 1ns/1ps
module dbnc_lane
  import dbnc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm,
  input  logic         raw,
  input  tidx_t        idx,
  input  period_bank_t periods,
  output logic         filt,
  output logic         move,
  output logic         busy,
  output logic         bypass
);
  period_t cnt_q;
  period_t period;
  tidx_t   idx_q;
  logic    differs, idx_chg, done;

  always_comb begin
    period  = period_for(idx, periods);
    bypass  = is_bypass(period);
    differs = raw ^ filt;
    idx_chg = (idx != idx_q);
    done    = count_done(cnt_q, period);
    move    = differs && (warm || bypass || (!idx_chg && done));
    busy    = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      idx_q <= idx;
      if (warm || bypass || !differs || idx_chg || done) cnt_q <= '0;
      else                                             cnt_q <= cnt_q + 1'b1;
      if (move) filt <= raw;
    end
  end
endmodule

// File: rtl/shared_debounce_filter.sv
`timescale 1ns/1ps
module shared_debounce_filter
  import dbnc_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = DBN_CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  pins_in,
  output logic [NPINS-1:0]  pins_out
);
  localparam int WARM_LEN = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_LEN + 1);

  period_t      sel_hi, sel_lo;
  period_bank_t periods;
  logic         addr_hit;
  logic [NPINS-1:0] sync_vec, out_move, lane_busy, lane_bypass;
  logic [WARM_W-1:0] warm_cnt;
  logic              warm;

  dbnc_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sel_hi(sel_hi), .sel_lo(sel_lo), .periods(periods),
    .addr_hit(addr_hit)
  );

  dbnc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pins_in), .q(sync_vec)
  );

  // Outputs track the synchronised input until the first valid sample has landed.
  assign warm = (warm_cnt != WARM_W'(WARM_LEN));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    warm_cnt <= '0;
    else if (warm) warm_cnt <= warm_cnt + 1'b1;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_lane
    dbnc_lane lane_i (
      .clk(clk), .rst_n(rst_n), .warm(warm), .raw(sync_vec[p]),
      .idx(timer_index(sel_hi[p], sel_lo[p])), .periods(periods),
      .filt(pins_out[p]), .move(out_move[p]), .busy(lane_busy[p]),
      .bypass(lane_bypass[p])
    );
  end
endmodule

// File: rtl/dbnc_checker.sv
`timescale 1ns/1ps
module dbnc_checker #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              addr_hit,
  input logic [NPINS-1:0]  pins_out,
  input logic [NPINS-1:0]  sync_vec,
  input logic [NPINS-1:0]  out_move,
  input logic [NPINS-1:0]  lane_busy,
  input logic [NPINS-1:0]  lane_bypass
);
  // R1
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hit) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (rdata == '0));

  // R3
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pins_out ^ $past(sync_vec)) & $past(lane_bypass)) == '0));

  // R5
  agree_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lane_busy & $past(~(sync_vec ^ pins_out))) == '0));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pins_out ^ $past(pins_out)) & ~$past(out_move)) == '0));

  // R10
  flip_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pins_out ^ $past(sync_vec)) & $past(out_move)) == '0));
endmodule

bind shared_debounce_filter dbnc_checker #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .addr_hit(addr_hit), .pins_out(pins_out),
  .sync_vec(sync_vec), .out_move(out_move), .lane_busy(lane_busy),
  .lane_bypass(lane_bypass)
);

// File: tb/shared_debounce_filter_tb_top.sv
`timescale 1ns/1ps
module shared_debounce_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins_in;
  logic [31:0] pins_out;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] model;
  logic [31:0] sh_hi = '0;
  logic [31:0] sh_lo = '0;

  typedef struct {
    int    at;
    int    pin;
    logic  val;
    string req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shared_debounce_filter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out)
  );

  function automatic void check(input bit ok, input string req,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  task automatic push(input int at, input int pin, input logic v, input string req);
    exp_t e;
    e.at = at; e.pin = pin; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares due scoreboard items at each falling edge.
  always @(negedge clk) begin
    for (int k = q.size() - 1; k >= 0; k--) begin
      if (q[k].at == cyc) begin
        check(pins_out[q[k].pin] == q[k].val, q[k].req,
              32'(pins_out[q[k].pin]), 32'(q[k].val));
        q.delete(k);
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  // Driver: applies pin levels and schedules the edge-exact expectations.
  task automatic drive(input logic [31:0] mask, input logic [31:0] val,
                       input int p, input string req);
    int c;
    @(negedge clk);
    c = cyc;
    for (int i = 0; i < 32; i++) begin
      if (mask[i] && (val[i] != model[i])) begin
        push(c + 1 + p, i, model[i], req);
        push(c + 2 + p, i, val[i], req);
      end
    end
    model   = (model & ~mask) | (val & mask);
    pins_in = (pins_in & ~mask) | (val & mask);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c;
    pins_in = 32'h5A00_0009;
    model   = pins_in;
    settle(3);
    // R9: reset state
    check(pins_out == '0, "R9", pins_out, '0);
    reg_read_chk(8'h50, '0, "R9");
    reg_read_chk(8'h40, '0, "R9");
    @(negedge clk) rst_n = 1'b1;
    settle(5);
    check(pins_out == model, "R9", pins_out, model);

    // R3: bypass pin, 3-edge latency
    drive(32'h0000_0020, 32'h0000_0020, 1, "R3");
    settle(6);

    // R1: program periods and selections, read back
    reg_write(8'h50, 32'd5);
    reg_write(8'h54, 32'd12);
    reg_write(8'h58, 32'd0);
    sh_hi = 32'h6; sh_lo = 32'h5;
    reg_write(8'h40, sh_hi);
    reg_write(8'h44, sh_lo);
    reg_read_chk(8'h50, 32'd5, "R1");
    reg_read_chk(8'h54, 32'd12, "R1");
    reg_read_chk(8'h58, 32'd0, "R1");
    reg_read_chk(8'h40, sh_hi, "R1");
    reg_read_chk(8'h44, sh_lo, "R1");

    // R4: timer 1 (5 cycles) and timer 2 (12 cycles)
    drive(32'h1, 32'h0, 5, "R4");
    settle(10);
    drive(32'h2, 32'h2, 12, "R4");
    settle(16);
    // R10: no other lane moved
    check(pins_out == model, "R10", pins_out, model);

    // R6: timer 3 with period 0
    drive(32'h4, 32'h4, 1, "R6");
    settle(5);

    // R5: short bounce on pin 0 (output 0) then a real change
    @(negedge clk);
    c = cyc;
    pins_in[0] = 1'b1;
    settle(3);
    pins_in[0] = 1'b0;
    push(c + 6, 0, 1'b0, "R5");
    settle(2);
    drive(32'h1, 32'h1, 5, "R5");
    settle(10);

    // R2: unmapped write ignored
    reg_write(8'h60, 32'hFFFF_FFFF);
    reg_read_chk(8'h60, '0, "R2");
    reg_read_chk(8'h50, 32'd5, "R2");
    reg_read_chk(8'h44, sh_lo, "R2");
    check(pins_out == model, "R2", pins_out, model);

    // R7: retune timer 1, shared by pins 0 and 3
    reg_write(8'h50, 32'd3);
    sh_lo = sh_lo | 32'h8;
    reg_write(8'h44, sh_lo);
    settle(2);
    drive(32'h9, 32'h0, 3, "R7");
    settle(8);

    // R8: move pin 1 from timer 2 to timer 3 mid-count
    reg_write(8'h58, 32'd4);
    settle(2);
    @(negedge clk);
    c = cyc;
    pins_in[1] = 1'b0;
    model[1] = 1'b0;
    push(c + 11, 1, 1'b1, "R8");
    push(c + 12, 1, 1'b0, "R8");
    settle(5);
    sh_lo = sh_lo | 32'h2;
    reg_write(8'h44, sh_lo);
    settle(10);

    // R3: many bypass pins at once
    drive(32'hFFFF_0000, ~model, 1, "R3");
    settle(6);
    check(pins_out == model, "R10", pins_out, model);

    settle(4);
    check(q.size() == 0, "R4", 32'(q.size()), 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule